// File: doc/BRIEF.md
# Circle Image Checker

This monitor sits beside a renderer's write path into a 16 by 16 one-bit frame image. It watches a single packet stream that carries two kinds of packet, pixel writes and sync markers. From the accepted writes it keeps its own copy of the image. When a sync marker says that a circle has just been finished, it walks its copy pixel by pixel and tests each one against the disc of the announced radius, centred at pixel (8,8).

The stream uses valid/busy flow control. While a check is running the monitor raises busy, so the renderer holds back and the image cannot change under the scan. When the scan ends, the monitor gives a one-cycle done pulse with a pass bit. It also reports the coordinates of the first pixel that broke the rule, counting in raster order.

Top module: `fbc_circle_checker`

## Requirements
- R1: After reset, busy and done are low and every pixel of the held image is 0, so a circle check of radius 0 run before any write passes.
- R2: A write packet (pkt_kind=0) stores wr_data at the pixel with x = wr_addr[3:0] and y = wr_addr[7:4]. wr_addr[15:8] is ignored. A later write to the same pixel replaces the earlier value.
- R3: A packet is accepted only in a cycle where pkt_valid is high and pkt_busy is low. A write presented while busy is high changes nothing until it is accepted.
- R4: A sync packet has pkt_kind=1 and carries a shape code on sync_shape (0 square, 1 circle, 2 triangle, 3 blank) and a radius on sync_radius. Only code 1 starts a check.
- R5: For radius r, the pixel at (x,y) is expected to be 1 exactly when (x-8)^2 + (y-8)^2 < r^2. Every other pixel is expected to be 0.
- R6: pkt_busy goes high in the cycle after a circle sync is accepted and stays high for exactly 256 cycles.
- R7: chk_done is high for exactly one cycle, the first cycle after busy falls. chk_pass in that cycle is 1 when all 256 pixels match.
- R8: On a failed check, bad_x and bad_y give the first mismatching pixel in the order y-major then x (y=0..15, x=0..15 within each row). They hold that value until the next check starts.
- R9: A sync packet with a shape code other than 1 is accepted, but no check starts: busy stays low and no done pulse follows.
- R10: The check uses the radius taken with the sync and the image as it stood before the sync. Changes on sync_radius during the scan have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet present on the stream |
| pkt_busy | output | 1 | Stream stalled while a check runs |
| pkt_kind | input | 1 | 0 = pixel write, 1 = sync marker |
| wr_addr | input | 16 | Pixel address of a write |
| wr_data | input | 1 | Pixel value of a write |
| sync_shape | input | 2 | Shape code of a sync |
| sync_radius | input | 3 | Radius of a sync |
| chk_done | output | 1 | One-cycle end-of-check pulse |
| chk_pass | output | 1 | Check result, valid with chk_done |
| bad_x | output | 4 | x of the first mismatching pixel |
| bad_y | output | 4 | y of the first mismatching pixel |

## Verification
The end of a check and the acceptance of the next packet can fall in the same cycle, because busy is already low while done pulses. The bench provokes this by raising a write during a scan and holding it, so that the write is taken in the done cycle. It then confirms that the finished result excludes that write and that the following check includes it.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int COORD_W = 4;
    localparam int IMG_DIM = 1 << COORD_W;
    localparam int IDX_W   = 2 * COORD_W;
    localparam int PIX_N   = IMG_DIM * IMG_DIM;
    localparam int CTR     = IMG_DIM / 2;
    localparam int ADDR_W  = 16;
    localparam int RAD_W   = 3;
    localparam int SQ_W    = 2 * COORD_W;

    typedef enum logic [1:0] {
        SHP_SQUARE   = 2'd0,
        SHP_CIRCLE   = 2'd1,
        SHP_TRIANGLE = 2'd2,
        SHP_BLANK    = 2'd3
    } shape_e;

    typedef enum logic {
        PK_WRITE = 1'b0,
        PK_SYNC  = 1'b1
    } pkt_kind_e;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } pix_pos_t;

    // distance of one coordinate from the image centre
    function automatic logic [COORD_W-1:0] ctr_dist(input logic [COORD_W-1:0] c);
        if (c >= COORD_W'(CTR)) return c - COORD_W'(CTR);
        else                    return COORD_W'(CTR) - c;
    endfunction

    // expected pixel value for a disc of radius r
    function automatic logic inside_disc(input pix_pos_t p, input logic [RAD_W-1:0] r);
        logic [SQ_W-1:0] ax, ay, rr;
        logic [SQ_W:0]   d2;
        ax = SQ_W'(ctr_dist(p.x));
        ay = SQ_W'(ctr_dist(p.y));
        rr = SQ_W'(r);
        d2 = (SQ_W+1)'(ax * ax) + (SQ_W+1)'(ay * ay);
        return d2 < (SQ_W+1)'(rr * rr);
    endfunction

endpackage

// File: rtl/fbc_shadow.sv
module fbc_shadow
    import fbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  pix_pos_t         wr_pos,
    input  logic             wr_bit,
    input  pix_pos_t         rd_pos,
    output logic             rd_bit,
    output logic [PIX_N-1:0] image
);

    always_ff @(posedge clk) begin
        if (rst)        image <= '0;
        else if (wr_en) image[IDX_W'(wr_pos)] <= wr_bit;
    end

    assign rd_bit = image[IDX_W'(rd_pos)];

    // R2: an accepted write lands at its pixel
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> image[IDX_W'($past(wr_pos))] == $past(wr_bit));

endmodule

// File: rtl/fbc_scan.sv
module fbc_scan
    import fbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [RAD_W-1:0] radius,
    input  logic             pix_bit,
    output pix_pos_t         rd_pos,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output pix_pos_t         bad_pos
);

    localparam int CNT_W = IDX_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PIX_N - 1);

    typedef enum logic {ST_IDLE, ST_SCAN} st_e;

    st_e              state;
    logic [CNT_W-1:0] cnt;
    logic [RAD_W-1:0] radius_q;
    logic             miss_q;
    logic             mismatch;

    assign rd_pos   = pix_pos_t'(cnt);
    assign busy     = (state == ST_SCAN);
    assign mismatch = pix_bit != inside_disc(rd_pos, radius_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            radius_q <= '0;
            miss_q   <= 1'b0;
            done     <= 1'b0;
            pass     <= 1'b0;
            bad_pos  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SCAN;
                        cnt      <= '0;
                        radius_q <= radius;
                        miss_q   <= 1'b0;
                        bad_pos  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (mismatch && !miss_q) begin
                        miss_q  <= 1'b1;
                        bad_pos <= rd_pos;
                    end
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        pass  <= !(miss_q || mismatch);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a start is followed by busy
    p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R7: busy falls only together with done
    p_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R7: done is a single pulse outside the scan
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));
    // R10: the radius in use stays fixed while scanning
    p_radius_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(radius_q));

endmodule

// File: rtl/fbc_circle_checker.sv
module fbc_circle_checker
    import fbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pkt_valid,
    output logic        pkt_busy,
    input  logic        pkt_kind,
    input  logic [15:0] wr_addr,
    input  logic        wr_data,
    input  logic [1:0]  sync_shape,
    input  logic [2:0]  sync_radius,
    output logic        chk_done,
    output logic        chk_pass,
    output logic [3:0]  bad_x,
    output logic [3:0]  bad_y
);

    logic             take;
    logic             wr_en;
    logic             start;
    logic             rd_bit;
    pix_pos_t         rd_pos;
    pix_pos_t         bad_pos;
    pix_pos_t         wr_pos;
    logic [PIX_N-1:0] image;

    assign take   = pkt_valid && !pkt_busy;
    assign wr_en  = take && (pkt_kind_e'(pkt_kind) == PK_WRITE);
    assign start  = take && (pkt_kind_e'(pkt_kind) == PK_SYNC)
                         && (shape_e'(sync_shape) == SHP_CIRCLE);
    assign wr_pos = pix_pos_t'(wr_addr[IDX_W-1:0]);

    fbc_shadow i_shadow (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_pos (wr_pos),
        .wr_bit (wr_data),
        .rd_pos (rd_pos),
        .rd_bit (rd_bit),
        .image  (image)
    );

    fbc_scan i_scan (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .radius  (sync_radius),
        .pix_bit (rd_bit),
        .rd_pos  (rd_pos),
        .busy    (pkt_busy),
        .done    (chk_done),
        .pass    (chk_pass),
        .bad_pos (bad_pos)
    );

    assign bad_x = bad_pos.x;
    assign bad_y = bad_pos.y;

    // R3: the image is frozen while busy
    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        pkt_busy |=> $stable(image));
    // R9: other shapes never start a scan
    p_other_shape_r9: assert property (@(posedge clk) disable iff (rst)
        (take && pkt_kind && (sync_shape != 2'd1)) |=> !pkt_busy);
    // R1: idle right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!pkt_busy && !chk_done));

endmodule

// File: tb/test_fbc_circle_checker.sv
module test_fbc_circle_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic        pkt_busy;
    logic        pkt_kind = 1'b0;
    logic [15:0] wr_addr = '0;
    logic        wr_data = 1'b0;
    logic [1:0]  sync_shape = '0;
    logic [2:0]  sync_radius = '0;
    logic        chk_done;
    logic        chk_pass;
    logic [3:0]  bad_x;
    logic [3:0]  bad_y;

    int n_checks = 0;
    int n_fails  = 0;
    bit mdl [256];

    fbc_circle_checker i_fbc_circle_checker (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_busy(pkt_busy),
        .pkt_kind(pkt_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .sync_shape(sync_shape), .sync_radius(sync_radius),
        .chk_done(chk_done), .chk_pass(chk_pass), .bad_x(bad_x), .bad_y(bad_y)
    );

    always #5 clk = ~clk;

    task automatic ck(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    function automatic bit want(int x, int y, int r);
        int dx = x - 8;
        int dy = y - 8;
        return (dx * dx + dy * dy) < (r * r);
    endfunction

    task automatic wr(input int x, input int y, input bit b, input int upper);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_kind = 1'b0;
        wr_addr = {8'(upper), 4'(y), 4'(x)}; wr_data = b;
        while (pkt_busy) @(negedge clk);
        @(posedge clk); #1;
        pkt_valid = 1'b0;
        mdl[y*16+x] = b;
    endtask

    task automatic draw(input int r);
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                wr(x, y, want(x, y, r), $urandom_range(255));
    endtask

    task automatic other_sync(input int shp);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_kind = 1'b1; sync_shape = 2'(shp); sync_radius = 3'd5;
        @(posedge clk); #1;
        pkt_valid = 1'b0;
        begin
            bit seen = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (pkt_busy || chk_done) seen = 1;
            end
            ck(!seen, "R9 other shape starts nothing", seen, 0);
        end
    endtask

    // circle check; intrude holds a write at (ix,iy) during the scan (R3)
    task automatic circle(input int r, input bit intrude, input int ix, input int iy, input bit ib);
        bit exp_pass = 1;
        int ex = 0, ey = 0;
        bit busy_ok = 1;
        int k;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                if (exp_pass && (mdl[y*16+x] != want(x, y, r))) begin
                    exp_pass = 0; ex = x; ey = y;
                end
        @(negedge clk);
        pkt_valid = 1'b1; pkt_kind = 1'b1; sync_shape = 2'd1; sync_radius = 3'(r);
        @(posedge clk); #1;
        pkt_valid = 1'b0;
        if (intrude) begin
            pkt_valid = 1'b1; pkt_kind = 1'b0;
            wr_addr = {8'h5A, 4'(iy), 4'(ix)}; wr_data = ib;
        end
        k = 0;
        while (k < 300) begin
            @(negedge clk);
            k++;
            sync_radius = 3'($urandom_range(7));  // R10: ignored mid-scan
            if (chk_done) break;
            if (!pkt_busy) busy_ok = 0;
        end
        ck(busy_ok, "R6 busy held through scan", busy_ok, 1);
        ck(k == 257, "R7 done timing", k, 257);
        ck(!pkt_busy, "R7 busy low at done", pkt_busy, 0);
        ck(chk_pass == exp_pass, "R5 R10 pass bit", chk_pass, exp_pass);
        if (!exp_pass) begin
            ck(bad_x == 4'(ex), "R8 first bad x", bad_x, ex);
            ck(bad_y == 4'(ey), "R8 first bad y", bad_y, ey);
        end
        if (intrude) begin
            @(posedge clk); #1;      // taken in the done cycle
            pkt_valid = 1'b0;
            mdl[iy*16+ix] = ib;
        end
        @(negedge clk);
        ck(!chk_done, "R7 single pulse", chk_done, 0);
        if (!exp_pass) begin
            ck(bad_x == 4'(ex) && bad_y == 4'(ey), "R8 position held",
               {bad_y, bad_x}, ey*16+ex);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mdl[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        ck(!pkt_busy, "R1 busy after reset", pkt_busy, 0);
        ck(!chk_done, "R1 done after reset", chk_done, 0);
        circle(0, 0, 0, 0, 0);                       // R1: blank image passes r=0

        draw(7);
        circle(7, 0, 0, 0, 0);                       // R5 full disc passes
        circle(3, 0, 0, 0, 0);                       // R5 wrong radius fails
        wr(15, 15, 1, 0);
        circle(7, 0, 0, 0, 0);                       // R8 last pixel
        wr(15, 15, 0, 8'hFF);                        // R2 last write wins, upper ignored
        wr(0, 0, 1, 8'h81);
        circle(7, 0, 0, 0, 0);                       // R8 first pixel
        wr(0, 0, 0, 0);
        other_sync(0); other_sync(2); other_sync(3); // R4 R9
        circle(7, 1, 8, 8, 0);                       // R3 write held during scan
        circle(7, 0, 0, 0, 0);                       // R3 write now counted

        for (int t = 0; t < 12; t++) begin
            int r = $urandom_range(7);
            draw(r);
            for (int f = $urandom_range(3); f > 0; f--) begin
                int x = $urandom_range(15);
                int y = $urandom_range(15);
                wr(x, y, !mdl[y*16+x], $urandom_range(255));
            end
            if ($urandom_range(1) == 1) other_sync($urandom_range(1) ? 0 : 3);
            circle(($urandom_range(3) == 0) ? $urandom_range(7) : r,
                   1'($urandom_range(1)), $urandom_range(15), $urandom_range(15),
                   1'($urandom_range(1)));
        end
        finish_run();
    end

endmodule